// File: doc/BRIEF.md
# Rail Reset Supervisor with Watchdog

This block drives the active-low system reset line of a power-management device. The line is modelled as an open-drain pull-down enable (`rst_pull_low` = 1 means the line is pulled low). The block combines two sources of reset. The first is a per-rail voltage window check fed by external comparator flags. The second is a programmable watchdog clocked by a slow tick.

The window check only considers rails that are enabled. While a power-up or power-down sequence is running, both the under-90% and the over-110% flags count as faults. In steady state only the under-90% flag counts. A rail that is slewing to a new voltage is also exempt in steady state. The fault is registered, so the reset line follows the flags one clock later and releases as soon as the fault clears.

The watchdog is a three-state machine:
- `WD_OFF`: the duration code is 0.
- `WD_RUN`: counting ticks toward the limit selected by the duration code.
- `WD_HOLD`: the reset is held low for a minimum number of ticks.

The named transitions are:
- arm: `WD_OFF` to `WD_RUN`, when the code becomes non-zero.
- disarm: `WD_RUN` to `WD_OFF`, when the code becomes 0.
- expire: `WD_RUN` to `WD_HOLD`, on the tick that reaches the limit.
- release: `WD_HOLD` to `WD_RUN`, or to `WD_OFF` if the code is 0, on the last hold tick.

On expiry the block pulses an interrupt, pulses a request to return all rails to mode 0 settings, and optionally latches a charge-suspend request.

Top module: `rail_reset_supervisor`

## Requirements
- R1: Out of reset all outputs are 0. When an enabled rail raises its under-90% flag, `rst_pull_low` is 1 in the cycle after the flag is sampled.
- R2: A rail whose `rail_en` bit is 0 never causes `rst_pull_low`, whatever its flags, slewing bit or sequencing state.
- R3: While `seq_active` is 1, an enabled rail with either its under-90% or its over-110% flag set holds `rst_pull_low` at 1. The slewing bit does not exempt a rail during sequencing.
- R4: While `seq_active` is 0, the over-110% flags are ignored.
- R5: While `seq_active` is 0, a rail with its `rail_slewing` bit set does not cause a window fault.
- R6: `rst_pull_low` returns to 0 in the cycle after the last window fault clears, provided the watchdog is not in `WD_HOLD`.
- R7: `wd_dur` selects the watchdog limit:
  - 2'b00 disables the watchdog (`WD_OFF`), and no expiry occurs.
  - 2'b01, 2'b10 and 2'b11 select `TICKS_D1`, `TICKS_D2` and `TICKS_D3` ticks.
  - Expiry happens on exactly the limit-th tick counted in `WD_RUN`.
- R8: In `WD_RUN`, the count restarts from zero on a `wdclr_wr` strobe with `wdclr_val` equal to 3'b001, or on a `mode_switch` pulse. A strobe with any other value has no effect.
- R9: On expiry, `wd_irq` and `force_mode0` are each high for exactly one cycle. `rst_pull_low` is held at 1 for `HOLD_TICKS` ticks. The watchdog then returns to `WD_RUN` with a cleared count.
- R10: On expiry with `wd_suspend_sel` = 1, `chg_suspend` becomes 1 and stays set until a `wdclr_wr` strobe with value 3'b001. With `wd_suspend_sel` = 0, `chg_suspend` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_en | input | N_RAILS | Per-rail enable of the active mode |
| rail_under | input | N_RAILS | Per-rail flag: output below 90% of target |
| rail_over | input | N_RAILS | Per-rail flag: output above 110% of target |
| seq_active | input | 1 | Power-up or power-down sequence in progress |
| rail_slewing | input | N_RAILS | Per-rail flag: rail moving to a new voltage level |
| mode_switch | input | 1 | One-cycle pulse on a mode setting change |
| wdclr_wr | input | 1 | Write strobe of the watchdog clear field |
| wdclr_val | input | 3 | Value written to the clear field |
| wd_dur | input | 2 | Watchdog duration code of the active mode |
| wd_suspend_sel | input | 1 | Expiry action: 1 also requests charge suspend |
| slow_tick | input | 1 | Watchdog time base, one-cycle pulses |
| rst_pull_low | output | 1 | Open-drain enable; 1 pulls the reset line low |
| wd_irq | output | 1 | One-cycle watchdog expiry interrupt |
| force_mode0 | output | 1 | One-cycle request to return rails to mode 0 |
| chg_suspend | output | 1 | Latched request to suspend charging |

## Verification
The bench fires the watchdog at exactly the limit-th tick for each non-zero code. A design with an off-by-one counter would expire one tick early or late and miss the interrupt check. A clear write of a value other than 3'b001 must not restart the count, so a decoder that treats any write as a clear expires late. Over-110% flags and slewing rails are applied both in and out of sequencing; a design that swapped the masking would pull reset low in steady state or miss a sequencing fault. The charge-suspend latch is checked for persistence through the hold and for release only on the clear write, and the hold pulse is checked for releasing exactly on its last tick.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_HOLD = 2'd2
    } wd_state_t;

    localparam logic [2:0] WD_CLEAR_KEY = 3'b001;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/rsv_window.sv
module rsv_window #(
    parameter int unsigned N_RAILS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_en,
    input  logic [N_RAILS-1:0] rail_under,
    input  logic [N_RAILS-1:0] rail_over,
    input  logic               seq_active,
    input  logic [N_RAILS-1:0] rail_slewing,
    output logic               fault_q
);
    logic [N_RAILS-1:0] seq_fault;
    logic [N_RAILS-1:0] run_fault;

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        // sequencing: both thresholds count; steady state: lower only, slewing exempt
        assign seq_fault[i] = rail_en[i] & (rail_under[i] | rail_over[i]);
        assign run_fault[i] = rail_en[i] & ~rail_slewing[i] & rail_under[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= seq_active ? (|seq_fault) : (|run_fault);
    end

    // R2
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en == '0) |=> !fault_q);
    // R3
    p_seq_low_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && |(rail_en & rail_under)) |=> fault_q);
    // R4 / R6
    p_steady_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active && ((rail_en & rail_under) == '0)) |=> !fault_q);
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
    import rsv_pkg::*;
#(
    parameter int unsigned TICKS_D1   = 8,
    parameter int unsigned TICKS_D2   = 16,
    parameter int unsigned TICKS_D3   = 32,
    parameter int unsigned HOLD_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] dur,
    input  logic       clr_wr,
    input  logic [2:0] clr_val,
    input  logic       mode_chg,
    input  logic       act_sel,
    output logic       wd_hold,
    output logic       wd_irq,
    output logic       force_m0,
    output logic       chg_susp
);
    localparam int unsigned MAXT = max3(TICKS_D1, TICKS_D2, TICKS_D3);
    localparam int unsigned CW   = $clog2(MAXT + 1);
    localparam int unsigned HCW  = $clog2(HOLD_TICKS + 1);

    wd_state_t       state, state_n;
    logic [CW-1:0]   cnt, cnt_n, limit;
    logic [HCW-1:0]  hcnt, hcnt_n;
    logic            expire, restart, clr_key;

    assign clr_key = clr_wr && (clr_val == WD_CLEAR_KEY);
    assign restart = clr_key || mode_chg;

    always_comb begin
        unique case (dur)
            2'd1:    limit = CW'(TICKS_D1);
            2'd2:    limit = CW'(TICKS_D2);
            2'd3:    limit = CW'(TICKS_D3);
            default: limit = '0;
        endcase
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        hcnt_n  = hcnt;
        expire  = 1'b0;
        unique case (state)
            WD_OFF: begin
                if (dur != 2'd0) begin        // arm
                    state_n = WD_RUN;
                    cnt_n   = '0;
                end
            end
            WD_RUN: begin
                if (dur == 2'd0) begin        // disarm
                    state_n = WD_OFF;
                    cnt_n   = '0;
                end else if (restart) begin
                    cnt_n = '0;
                end else if (tick) begin
                    if (cnt >= limit - 1'b1) begin  // expire
                        expire  = 1'b1;
                        state_n = WD_HOLD;
                        cnt_n   = '0;
                        hcnt_n  = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            WD_HOLD: begin
                if (tick) begin
                    if (hcnt == HCW'(HOLD_TICKS - 1)) begin  // release
                        state_n = (dur != 2'd0) ? WD_RUN : WD_OFF;
                        hcnt_n  = '0;
                        cnt_n   = '0;
                    end else begin
                        hcnt_n = hcnt + 1'b1;
                    end
                end
            end
            default: state_n = WD_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
            hcnt  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            hcnt  <= hcnt_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_irq   <= 1'b0;
            force_m0 <= 1'b0;
            chg_susp <= 1'b0;
        end else begin
            wd_irq   <= expire;
            force_m0 <= expire;
            if (expire && act_sel) chg_susp <= 1'b1;
            else if (clr_key)      chg_susp <= 1'b0;
        end
    end

    assign wd_hold = (state == WD_HOLD);

    // R9
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |=> !wd_irq);
    // R9
    p_irq_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_hold);
    // R7
    p_off_no_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dur == 2'd0) |=> !wd_irq);
    // R10
    p_suspend_needs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_susp) |-> (wd_irq && $past(act_sel)));
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor #(
    parameter int unsigned N_RAILS    = 4,
    parameter int unsigned TICKS_D1   = 8,
    parameter int unsigned TICKS_D2   = 16,
    parameter int unsigned TICKS_D3   = 32,
    parameter int unsigned HOLD_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_en,
    input  logic [N_RAILS-1:0] rail_under,
    input  logic [N_RAILS-1:0] rail_over,
    input  logic               seq_active,
    input  logic [N_RAILS-1:0] rail_slewing,
    input  logic               mode_switch,
    input  logic               wdclr_wr,
    input  logic [2:0]         wdclr_val,
    input  logic [1:0]         wd_dur,
    input  logic               wd_suspend_sel,
    input  logic               slow_tick,
    output logic               rst_pull_low,
    output logic               wd_irq,
    output logic               force_mode0,
    output logic               chg_suspend
);
    logic win_fault;
    logic wd_hold;

    rsv_window #(.N_RAILS(N_RAILS)) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_en      (rail_en),
        .rail_under   (rail_under),
        .rail_over    (rail_over),
        .seq_active   (seq_active),
        .rail_slewing (rail_slewing),
        .fault_q      (win_fault)
    );

    rsv_wdog #(
        .TICKS_D1   (TICKS_D1),
        .TICKS_D2   (TICKS_D2),
        .TICKS_D3   (TICKS_D3),
        .HOLD_TICKS (HOLD_TICKS)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slow_tick),
        .dur      (wd_dur),
        .clr_wr   (wdclr_wr),
        .clr_val  (wdclr_val),
        .mode_chg (mode_switch),
        .act_sel  (wd_suspend_sel),
        .wd_hold  (wd_hold),
        .wd_irq   (wd_irq),
        .force_m0 (force_mode0),
        .chg_susp (chg_suspend)
    );

    assign rst_pull_low = win_fault | wd_hold;

    // R9: expiry always pulls the reset line
    p_wd_drives_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> rst_pull_low);
    // R9: mode 0 request accompanies the interrupt
    p_force_with_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_mode0 |-> wd_irq);
endmodule

// File: tb/rail_reset_supervisor_test.sv
module rail_reset_supervisor_test;
    localparam int N = 4, T1 = 8, T2 = 16, T3 = 32, HT = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [N-1:0] rail_en = '0, rail_under = '0, rail_over = '0, rail_slewing = '0;
    logic         seq_active = 1'b0, mode_switch = 1'b0, wdclr_wr = 1'b0;
    logic [2:0]   wdclr_val = 3'b000;
    logic [1:0]   wd_dur = 2'b00;
    logic         wd_suspend_sel = 1'b0, slow_tick = 1'b0;
    logic         rst_pull_low, wd_irq, force_mode0, chg_suspend;

    rail_reset_supervisor #(
        .N_RAILS(N), .TICKS_D1(T1), .TICKS_D2(T2), .TICKS_D3(T3), .HOLD_TICKS(HT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_under(rail_under),
        .rail_over(rail_over), .seq_active(seq_active), .rail_slewing(rail_slewing),
        .mode_switch(mode_switch), .wdclr_wr(wdclr_wr), .wdclr_val(wdclr_val),
        .wd_dur(wd_dur), .wd_suspend_sel(wd_suspend_sel), .slow_tick(slow_tick),
        .rst_pull_low(rst_pull_low), .wd_irq(wd_irq), .force_mode0(force_mode0),
        .chg_suspend(chg_suspend)
    );

    typedef struct {
        int    due;
        string tag;
        logic  r, i, f, s;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(exp_t e);
        checks++;
        if (rst_pull_low !== e.r || wd_irq !== e.i || force_mode0 !== e.f || chg_suspend !== e.s) begin
            fails++;
            $display("FAIL %s: got rst=%b irq=%b f0=%b sus=%b, expected rst=%b irq=%b f0=%b sus=%b",
                     e.tag, rst_pull_low, wd_irq, force_mode0, chg_suspend, e.r, e.i, e.f, e.s);
        end
    endtask

    // monitor: pops expected items as their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                compare(q.pop_front());
            end
        end
    end

    task automatic expect_next(string tag, logic r, logic i, logic f, logic s);
        exp_t e;
        e.due = cyc + 1; e.tag = tag; e.r = r; e.i = i; e.f = f; e.s = s;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic win(string tag, logic [N-1:0] en, logic [N-1:0] un, logic [N-1:0] ov,
                       logic sq, logic [N-1:0] sl, logic exp_r);
        rail_en = en; rail_under = un; rail_over = ov; seq_active = sq; rail_slewing = sl;
        expect_next(tag, exp_r, 1'b0, 1'b0, 1'b0);
        step();
    endtask

    task automatic quiet_step(string tag, logic s);
        expect_next(tag, 1'b0, 1'b0, 1'b0, s);
        step();
    endtask

    task automatic run_ticks(int n, string tag, logic s);
        for (int k = 0; k < n; k++) begin
            slow_tick = 1'b1;
            expect_next(tag, 1'b0, 1'b0, 1'b0, s);
            step();
        end
        slow_tick = 1'b0;
    endtask

    task automatic expire_and_hold(string tag, logic s);
        slow_tick = 1'b1;
        expect_next(tag, 1'b1, 1'b1, 1'b1, s);
        step();
        slow_tick = 1'b0;
        expect_next("R9 irq single cycle", 1'b1, 1'b0, 1'b0, s);
        step();
        for (int k = 0; k < HT - 1; k++) begin
            slow_tick = 1'b1;
            expect_next("R9 hold low", 1'b1, 1'b0, 1'b0, s);
            step();
        end
        slow_tick = 1'b1;
        expect_next("R9 hold release", 1'b0, 1'b0, 1'b0, s);
        step();
        slow_tick = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        quiet_step("R1 reset state", 1'b0);

        // window checks
        win("R1 enabled rail under",     4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b1);
        win("R6 release after fault",    4'b0001, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0);
        win("R2 disabled rails ignored", 4'b0000, 4'b1111, 4'b1111, 1'b1, 4'b0000, 1'b0);
        win("R2 disabled steady",        4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b0);
        win("R3 seq under",              4'b0011, 4'b0010, 4'b0000, 1'b1, 4'b0000, 1'b1);
        win("R3 seq over",               4'b0011, 4'b0000, 4'b0001, 1'b1, 4'b0000, 1'b1);
        win("R3 seq slewing not exempt", 4'b0011, 4'b0001, 4'b0000, 1'b1, 4'b0001, 1'b1);
        win("R6 seq all in window",      4'b0011, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b0);
        win("R4 steady over ignored",    4'b0011, 4'b0000, 4'b0011, 1'b0, 4'b0000, 1'b0);
        win("R5 slewing rail masked",    4'b0011, 4'b0001, 4'b0000, 1'b0, 4'b0001, 1'b0);
        win("R5 slew done fault shows",  4'b0011, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b1);
        win("R6 clear",                  4'b0011, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0);

        // watchdog, code 1
        wd_dur = 2'd1;
        quiet_step("R7 arm", 1'b0);
        run_ticks(T1 - 1, "R7 no early expiry code1", 1'b0);
        expire_and_hold("R7 expiry at limit code1", 1'b0);

        // non-key clear write ignored
        run_ticks(5, "R8 counting", 1'b0);
        wdclr_wr = 1'b1; wdclr_val = 3'b010;
        quiet_step("R8 non-key write", 1'b0);
        wdclr_wr = 1'b0;
        run_ticks(T1 - 5 - 1, "R8 counting on", 1'b0);
        expire_and_hold("R8 non-key write no restart", 1'b0);

        // key clear write restarts
        run_ticks(5, "R8 counting", 1'b0);
        wdclr_wr = 1'b1; wdclr_val = 3'b001;
        quiet_step("R8 key write", 1'b0);
        wdclr_wr = 1'b0;
        run_ticks(T1 - 1, "R8 restarted by key write", 1'b0);
        expire_and_hold("R8 expiry after key restart", 1'b0);

        // mode change restarts
        run_ticks(5, "R8 counting", 1'b0);
        mode_switch = 1'b1;
        quiet_step("R8 mode change", 1'b0);
        mode_switch = 1'b0;
        run_ticks(T1 - 1, "R8 restarted by mode change", 1'b0);
        expire_and_hold("R8 expiry after mode restart", 1'b0);

        // code 2 with suspend
        wd_dur = 2'd2; wd_suspend_sel = 1'b1;
        quiet_step("R7 code2 select", 1'b0);
        run_ticks(T2 - 1, "R7 no early expiry code2", 1'b0);
        expire_and_hold("R10 expiry sets suspend", 1'b1);
        quiet_step("R10 suspend persists", 1'b1);
        wdclr_wr = 1'b1; wdclr_val = 3'b011;
        quiet_step("R10 non-key keeps suspend", 1'b1);
        wdclr_val = 3'b001;
        quiet_step("R10 key write clears suspend", 1'b0);
        wdclr_wr = 1'b0; wd_suspend_sel = 1'b0;

        // code 3
        wd_dur = 2'd3;
        quiet_step("R7 code3 select", 1'b0);
        run_ticks(T3 - 1, "R7 no early expiry code3", 1'b0);
        expire_and_hold("R7 expiry at limit code3", 1'b0);

        // disabled
        wd_dur = 2'd0;
        quiet_step("R7 disarm", 1'b0);
        run_ticks(T3 + 8, "R7 code0 never expires", 1'b0);

        repeat (3) step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule